// File: doc/BRIEF.md
# Ancillary Trigger Validation Gate

This block sits between a local detector front-end and a global trigger system and runs the per-event handshake between them. A prompt trigger request starts an event at once: the block answers with a one-cycle local trigger that carries an 8-bit tag, and raises a busy line while the converters run. The global decision comes much later, as a pulse on either a validate line or a reject line, with the tag of the event it refers to. Only validated events whose conversion has finished are passed to the readout side, each with a 32-bit event number. Rejected events, and events that get no decision within a set number of cycles, are dropped.

Two modes are chosen with a static input. In slow mode a single event is handled at a time. Every request is ignored from acceptance until that event is dropped or read out, so the dead time is shared. In fast mode two events can be in flight at once. Each has its own slot, its own tag and its own busy bit, so a second conversion can run while the first event still waits for its decision.

The readout port is valid/ready. An item stays on the port, unchanged, until the consumer takes it with ready high. While the consumer holds ready low, the slot stays occupied, so in slow mode back-pressure stretches the dead time. A decision whose tag matches no event awaiting a decision sets a sticky error flag and has no other effect.

Top module: `anc_trig_gate`

## Requirements
- R1: After reset, local_trig, busy, ro_valid and tag_err are 0. The first accepted request gets tag 0, and the first validated event gets event number 0.
- R2: An accepted request makes local_trig high for exactly the next cycle, with local_tag equal to the current tag. The tag then increases by one modulo 256, so 255 is followed by 0.
- R3: busy[k] goes high in the same cycle as the local trigger of the event placed in slot k. It goes low in the cycle after conv_done[k] is sampled high. In fast mode, slot 0 is used when it is free and slot 1 otherwise.
- R4: In slow mode (mode_fast = 0), a trigger request gives no local trigger and changes no state while an event is held. An event is held from acceptance until it is rejected, times out, or is taken by the readout.
- R5: In fast mode (mode_fast = 1), a second request is accepted while the first event is held, and both busy bits can be high together. A request made while both slots are held is ignored.
- R6: A validate pulse (dec_val high, dec_rej low) whose dec_tag matches a held event still awaiting its decision gives that event the next event number. One readout item {ro_evnum, ro_tag} follows once the event's conversion has finished. This is also true when the validate arrives during the conversion.
- R7: A reject pulse with a matching tag drops the event. No readout item is produced, and the slot is free for a new request from the next cycle.
- R8: A decision whose tag matches no held event awaiting a decision sets tag_err. tag_err stays set until reset, and the decision changes no event.
- R9: An event that gets no decision within TIMEOUT cycles of its acceptance is dropped without a readout. A decision that arrives later for its tag is treated as unmatched (R8).
- R10: While ro_valid is high and ro_ready is low, ro_valid, ro_evnum and ro_tag stay unchanged. Items are presented in the order their events became ready. When two events become ready in the same cycle, the lower event number goes first.
- R11: A decision with dec_val and dec_rej both high counts as a reject.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fast | input | 1 | 0: one event at a time; 1: two events in flight |
| trig_req | input | 1 | Prompt trigger request, sampled every cycle |
| local_trig | output | 1 | One-cycle local trigger to the front-end |
| local_tag | output | TAG_W | Tag of the event started by local_trig |
| busy | output | 2 | Per-slot conversion-in-progress |
| conv_done | input | 2 | Per-slot conversion finished pulse |
| dec_val | input | 1 | Validate decision pulse |
| dec_rej | input | 1 | Reject decision pulse |
| dec_tag | input | TAG_W | Tag the decision refers to |
| ro_valid | output | 1 | Readout item available |
| ro_ready | input | 1 | Readout consumer accepts the item |
| ro_evnum | output | EVT_W | Event number of the item |
| ro_tag | output | TAG_W | Tag of the item |
| tag_err | output | 1 | Sticky unmatched-decision flag |

## Verification
The assertions take four things for granted about the inputs. mode_fast changes only while no event is held. conv_done[k] pulses only while slot k is busy. At most one decision arrives per cycle. ro_ready is a plain level that the consumer may drop at any time. The stimulus changes mode only after every slot has drained and the readout queue is empty. It pulses conv_done only for slots it has just started, and it spaces decisions at least two cycles apart. The ready line is driven constant high, alternating, or held low, so the hold rule is exercised under real back-pressure.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [2:0] {
    SL_FREE  = 3'd0,
    SL_CONV  = 3'd1,  // converting, no decision yet
    SL_CVAL  = 3'd2,  // converting, already validated
    SL_WAIT  = 3'd3,  // converted, awaiting decision
    SL_READY = 3'd4   // converted and validated, for readout
  } slot_st_e;
endpackage

// File: rtl/anc_slot.sv
module anc_slot
  import anc_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int EVT_W   = 32,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             conv_done,
  input  logic             dec_val,
  input  logic             dec_rej,
  input  logic [TAG_W-1:0] dec_tag,
  input  logic [EVT_W-1:0] ev_in,
  input  logic             take,
  output logic             used,
  output logic             busy,
  output logic             ready,
  output logic             hit,
  output logic             val_hit,
  output logic [TAG_W-1:0] tag_q,
  output logic [EVT_W-1:0] ev_q
);
  localparam int TMO_W = $clog2(TIMEOUT + 1);

  slot_st_e         st_q;
  logic [TMO_W-1:0] tmo_q;
  logic             pend, rej_hit, expire;

  assign pend    = (st_q == SL_CONV) || (st_q == SL_WAIT);
  assign hit     = pend && (dec_val || dec_rej) && (dec_tag == tag_q);
  assign rej_hit = hit && dec_rej;
  assign val_hit = hit && !dec_rej;
  assign expire  = pend && !hit && (tmo_q == TMO_W'(TIMEOUT - 1));

  assign used  = (st_q != SL_FREE);
  assign busy  = (st_q == SL_CONV) || (st_q == SL_CVAL);
  assign ready = (st_q == SL_READY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SL_FREE;
      tag_q <= '0;
      ev_q  <= '0;
      tmo_q <= '0;
    end else begin
      if (pend) tmo_q <= tmo_q + 1'b1;
      if (val_hit) ev_q <= ev_in;
      unique case (st_q)
        SL_FREE: if (alloc) begin
          st_q  <= SL_CONV;
          tag_q <= alloc_tag;
          tmo_q <= '0;
        end
        SL_CONV: begin
          if (rej_hit || expire)  st_q <= SL_FREE;
          else if (val_hit)       st_q <= conv_done ? SL_READY : SL_CVAL;
          else if (conv_done)     st_q <= SL_WAIT;
        end
        SL_CVAL: if (conv_done) st_q <= SL_READY;
        SL_WAIT: begin
          if (rej_hit || expire)  st_q <= SL_FREE;
          else if (val_hit)       st_q <= SL_READY;
        end
        SL_READY: if (take) st_q <= SL_FREE;
        default: st_q <= SL_FREE;
      endcase
    end
  end
endmodule

// File: rtl/anc_ro_arb.sv
module anc_ro_arb #(
  parameter int EVT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ready,
  input  logic [EVT_W-1:0] ev0,
  input  logic [EVT_W-1:0] ev1,
  input  logic             ro_ready,
  output logic             ro_valid,
  output logic             sel,
  output logic [1:0]       take
);
  logic             held_q, sel_q, pick1;
  logic [EVT_W-1:0] diff;

  // wrap-safe age compare: ev1 older when (ev1 - ev0) is negative
  assign diff  = ev1 - ev0;
  assign pick1 = ready[1] && (!ready[0] || diff[EVT_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (!held_q) begin
      if (|ready) begin
        held_q <= 1'b1;
        sel_q  <= pick1;
      end
    end else if (ro_ready) begin
      held_q <= 1'b0;
    end
  end

  assign ro_valid = held_q;
  assign sel      = sel_q;
  assign take     = (held_q && ro_ready) ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
endmodule

// File: rtl/anc_trig_gate.sv
module anc_trig_gate
  import anc_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int EVT_W   = 32,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_fast,
  input  logic             trig_req,
  output logic             local_trig,
  output logic [TAG_W-1:0] local_tag,
  output logic [1:0]       busy,
  input  logic [1:0]       conv_done,
  input  logic             dec_val,
  input  logic             dec_rej,
  input  logic [TAG_W-1:0] dec_tag,
  output logic             ro_valid,
  input  logic             ro_ready,
  output logic [EVT_W-1:0] ro_evnum,
  output logic [TAG_W-1:0] ro_tag,
  output logic             tag_err
);
  logic [NSLOT-1:0] used_w, ready_w, hit_w, vhit_w, alloc_w, take_w;
  logic [TAG_W-1:0] tag_w [NSLOT];
  logic [EVT_W-1:0] ev_w  [NSLOT];
  logic [TAG_W-1:0] tag_cnt_q;
  logic [EVT_W-1:0] ev_cnt_q;
  logic             accept, trig_q, err_q, sel_w;
  logic [TAG_W-1:0] ltag_q;

  // slow mode: any held slot blocks; fast mode: need a free slot
  assign accept  = trig_req && (mode_fast ? !(&used_w) : !(|used_w));
  assign alloc_w = !accept ? 2'b00 : (!used_w[0] ? 2'b01 : 2'b10);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    anc_slot #(.TAG_W(TAG_W), .EVT_W(EVT_W), .TIMEOUT(TIMEOUT)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_w[k]),
      .alloc_tag (tag_cnt_q),
      .conv_done (conv_done[k]),
      .dec_val   (dec_val),
      .dec_rej   (dec_rej),
      .dec_tag   (dec_tag),
      .ev_in     (ev_cnt_q),
      .take      (take_w[k]),
      .used      (used_w[k]),
      .busy      (busy[k]),
      .ready     (ready_w[k]),
      .hit       (hit_w[k]),
      .val_hit   (vhit_w[k]),
      .tag_q     (tag_w[k]),
      .ev_q      (ev_w[k])
    );
  end

  anc_ro_arb #(.EVT_W(EVT_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready_w),
    .ev0      (ev_w[0]),
    .ev1      (ev_w[1]),
    .ro_ready (ro_ready),
    .ro_valid (ro_valid),
    .sel      (sel_w),
    .take     (take_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_cnt_q <= '0;
      ev_cnt_q  <= '0;
      trig_q    <= 1'b0;
      ltag_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      trig_q <= accept;
      if (accept) begin
        ltag_q    <= tag_cnt_q;
        tag_cnt_q <= tag_cnt_q + 1'b1;
      end
      if (|vhit_w) ev_cnt_q <= ev_cnt_q + 1'b1;
      if ((dec_val || dec_rej) && !(|hit_w)) err_q <= 1'b1;
    end
  end

  assign local_trig = trig_q;
  assign local_tag  = ltag_q;
  assign tag_err    = err_q;
  assign ro_evnum   = sel_w ? ev_w[1]  : ev_w[0];
  assign ro_tag     = sel_w ? tag_w[1] : tag_w[0];
endmodule

// File: rtl/anc_trig_gate_chk.sv
module anc_trig_gate_chk #(
  parameter int TAG_W = 8,
  parameter int EVT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_fast,
  input logic             trig_req,
  input logic             local_trig,
  input logic [1:0]       busy,
  input logic [1:0]       used_w,
  input logic             tag_err,
  input logic             ro_valid,
  input logic             ro_ready,
  input logic [EVT_W-1:0] ro_evnum,
  input logic [TAG_W-1:0] ro_tag
);
  p_trig_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    local_trig |-> $past(trig_req));

  p_busy_with_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    local_trig |-> (busy != 2'b00));

  p_slow_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_fast |-> ($countones(used_w) <= 1));

  p_slow_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_fast && (used_w != 2'b00) && trig_req) |=> !local_trig);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err);

  p_ro_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_valid && !ro_ready) |=> (ro_valid && $stable(ro_evnum) && $stable(ro_tag)));
endmodule

bind anc_trig_gate anc_trig_gate_chk #(.TAG_W(TAG_W), .EVT_W(EVT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_fast  (mode_fast),
  .trig_req   (trig_req),
  .local_trig (local_trig),
  .busy       (busy),
  .used_w     (used_w),
  .tag_err    (tag_err),
  .ro_valid   (ro_valid),
  .ro_ready   (ro_ready),
  .ro_evnum   (ro_evnum),
  .ro_tag     (ro_tag)
);

// File: tb/anc_trig_gate_tb.sv
module anc_trig_gate_tb;
  localparam int TMO = 64;

  logic        clk = 1'b0, rst_n = 1'b0, mode_fast = 1'b0, trig_req = 1'b0;
  logic [1:0]  conv_done = 2'b00;
  logic        dec_val = 1'b0, dec_rej = 1'b0;
  logic [7:0]  dec_tag = 8'h00;
  logic        ro_ready = 1'b0;
  logic        local_trig, ro_valid, tag_err;
  logic [7:0]  local_tag, ro_tag;
  logic [1:0]  busy;
  logic [31:0] ro_evnum;

  anc_trig_gate #(.TAG_W(8), .EVT_W(32), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .trig_req(trig_req),
    .local_trig(local_trig), .local_tag(local_tag), .busy(busy),
    .conv_done(conv_done), .dec_val(dec_val), .dec_rej(dec_rej),
    .dec_tag(dec_tag), .ro_valid(ro_valid), .ro_ready(ro_ready),
    .ro_evnum(ro_evnum), .ro_tag(ro_tag), .tag_err(tag_err)
  );

  always #4 clk = ~clk;

  typedef struct packed { logic [31:0] ev; logic [7:0] tag; } item_t;
  item_t       exp_q[$];
  int          checks = 0, errors = 0, rr_mode = 0;
  logic [7:0]  tag_exp = 8'h00;
  logic [31:0] ev_exp  = 32'h0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ready driver: 0 always high, 1 alternating, 2 held low
  initial forever begin
    @(posedge clk); #2;
    case (rr_mode)
      0: ro_ready = 1'b1;
      1: ro_ready = ~ro_ready;
      default: ro_ready = 1'b0;
    endcase
  end

  // monitor: pops the scoreboard on each handshake, checks hold under back-pressure
  logic  prev_hold = 1'b0;
  item_t prev_it, got;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) chk("R10", {ro_valid, ro_evnum, ro_tag}, {1'b1, prev_it}, "held item");
      if (ro_valid && ro_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected readout: actual ev %0d tag %0h expected none", ro_evnum, ro_tag);
        end else begin
          got = exp_q.pop_front();
          chk("R6", {ro_evnum, ro_tag}, got, "readout item");
        end
      end
      prev_hold = ro_valid && !ro_ready;
      prev_it   = {ro_evnum, ro_tag};
    end else prev_hold = 1'b0;
  end

  task automatic request(bit acc, int slot, string req);
    @(negedge clk); trig_req = 1'b1;
    @(negedge clk); trig_req = 1'b0;
    chk(req, local_trig, acc, "local trigger");
    if (acc) begin
      chk("R2", local_tag, tag_exp, "local tag");
      chk("R3", busy[slot], 1'b1, "busy set");
      tag_exp++;
    end
  endtask

  task automatic done(int slot);
    @(negedge clk); conv_done[slot] = 1'b1;
    @(negedge clk); conv_done = 2'b00;
    chk("R3", busy[slot], 1'b0, "busy cleared");
  endtask

  task automatic decide(logic [7:0] t, bit v, bit r, bit push);
    @(negedge clk); dec_tag = t; dec_val = v; dec_rej = r;
    if (push) begin exp_q.push_back({ev_exp, t}); ev_exp++; end
    @(negedge clk); dec_val = 1'b0; dec_rej = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1", {local_trig, busy, ro_valid, tag_err}, 5'b0, "reset outputs");
    rst_n = 1'b1;

    // slow mode: basic event, ignored requests during conversion and wait
    request(1'b1, 0, "R2");
    request(1'b0, 0, "R4");
    chk("R4", busy[0], 1'b1, "busy untouched by ignored request");
    done(0);
    request(1'b0, 0, "R4");
    decide(8'd0, 1'b1, 1'b0, 1'b1);
    idle(6);
    chk("R6", exp_q.size(), 0, "first event read out");

    // validate during conversion
    request(1'b1, 0, "R2");
    decide(8'd1, 1'b1, 1'b0, 1'b1);
    idle(3);
    chk("R6", ro_valid, 1'b0, "no readout before conversion done");
    done(0);
    idle(6);
    chk("R6", exp_q.size(), 0, "validated-early event read out");

    // reject, then both lines high
    request(1'b1, 0, "R2");
    done(0);
    decide(8'd2, 1'b0, 1'b1, 1'b0);
    idle(4);
    request(1'b1, 0, "R7");
    done(0);
    decide(8'd3, 1'b1, 1'b1, 1'b0);
    idle(4);
    request(1'b1, 0, "R11");

    // back-pressure holds slot and item
    done(0);
    rr_mode = 2;
    decide(8'd4, 1'b1, 1'b0, 1'b1);
    idle(5);
    chk("R10", ro_valid, 1'b1, "item waiting under back-pressure");
    request(1'b0, 0, "R4");
    rr_mode = 0;
    idle(6);
    chk("R10", exp_q.size(), 0, "held item drained");

    // fast mode: two in flight, third ignored, out-of-order validation
    mode_fast = 1'b1;
    request(1'b1, 0, "R5");
    request(1'b1, 1, "R5");
    chk("R5", busy, 2'b11, "both slots converting");
    request(1'b0, 0, "R5");
    done(0);
    done(1);
    rr_mode = 1;
    decide(8'd6, 1'b1, 1'b0, 1'b1);
    decide(8'd5, 1'b1, 1'b0, 1'b1);
    idle(20);
    chk("R10", exp_q.size(), 0, "fast-mode items in readiness order");
    rr_mode = 0;
    mode_fast = 1'b0;

    // timeout
    request(1'b1, 0, "R2");
    done(0);
    chk("R9", tag_err, 1'b0, "no error before late decision");
    idle(TMO + 10);
    request(1'b1, 0, "R9");
    decide(8'd7, 1'b1, 1'b0, 1'b0);
    chk("R9", tag_err, 1'b1, "late decision unmatched");
    done(0);
    decide(8'd8, 1'b0, 1'b1, 1'b0);
    idle(4);

    // second reset, then unmatched tag
    rst_n = 1'b0;
    idle(2);
    chk("R1", {local_trig, busy, ro_valid, tag_err}, 5'b0, "outputs after second reset");
    rst_n = 1'b1;
    tag_exp = 8'h00; ev_exp = 32'h0;
    request(1'b1, 0, "R1");
    decide(8'hEE, 1'b1, 1'b0, 1'b0);
    chk("R8", tag_err, 1'b1, "unmatched tag flagged");
    chk("R8", busy[0], 1'b1, "held event untouched");
    done(0);
    decide(8'd0, 1'b1, 1'b0, 1'b1);
    idle(6);
    chk("R1", exp_q.size(), 0, "event number restarts at 0");
    chk("R8", tag_err, 1'b1, "error flag sticky");

    // tag wrap 255 -> 0, each event rejected during conversion
    for (int i = 0; i < 256; i++) begin
      request(1'b1, 0, "R2");
      decide(tag_exp - 8'd1, 1'b0, 1'b1, 1'b0);
    end
    chk("R2", tag_exp, 8'd1, "tag wrapped modulo 256");
    idle(6);
    chk("R7", exp_q.size(), 0, "no leftover items");
    finish_run();
  end
endmodule